// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Decoder

This block sits between a processor whose address and data share pins and the memory and I/O behind it. On the address-latch strobe it captures a 20-bit address and a byte-high-enable flag and holds them for the rest of the bus cycle. In the status phase, while a read or write strobe is active, it records the segment code carried on the upper shared lines as a one-hot vector, keeps the interrupt-enable status bit, and raises a sticky error if the reserved status bit is ever high.

From the memory/I-O select line and the processor's read and write strobes it produces four active-low strobes: memory read, memory write, I/O read and I/O write. It also drives the enable and direction pins of a bidirectional data transceiver and produces even-bank and odd-bank byte enables. The parameter `DW` chooses a 16-bit data path (two byte banks, select high means memory) or an 8-bit data path (one byte lane, select high means I/O). In the 8-bit variant, address bits 8 to 15 arrive on dedicated lines. Both variants receive them on `abus[15:8]`.

Reset only takes effect after it has been high for `RST_CYC` consecutive clock edges. A shorter pulse is ignored.

Top module: `mux_bus_demux`

## Requirements
- R1: On each rising edge with `ale` high, `addr` takes `{ast, abus}` and the stored byte-high flag takes `bhe_n`. The segment vector clears to 0.
- R2: While `ale` is low, `addr` and the stored byte-high flag hold their values, whatever `abus` and `ast` do.
- R3: On a rising edge with `ale` low and `rd_n` or `wr_n` low, `seg` becomes one-hot from `ast[1:0]`: code 0 gives bit 0 (extra), 1 gives bit 1 (stack), 2 gives bit 2 (code or none), and 3 gives bit 3 (data).
- R4: On the same status edge, `ie_flag` takes `ast[2]`.
- R5: On a status edge with `ast[3]` high, `s6_err` is set. It stays set until an accepted reset.
- R6: With `DW`=16, `ben_even` = NOT `addr[0]` and `ben_odd` = NOT the stored byte-high flag. This gives: word = both, odd only, even only, none.
- R7: With `DW`=8, `ben_even` is 1 and `ben_odd` is 0 outside reset.
- R8: `mem_rd_n`, `mem_wr_n`, `io_rd_n` and `io_wr_n` follow `rd_n`/`wr_n` combinationally, routed by `mio`. In the 16-bit variant `mio`=1 selects memory. In the 8-bit variant `mio`=1 selects I/O.
- R9: `den_n` is low exactly when `rd_n` or `wr_n` is low.
- R10: `dt_r` is high exactly while `wr_n` is low, meaning data flows out of the processor. Otherwise it is low.
- R11: Reset is accepted only on the edge that completes `RST_CYC` (4) consecutive high samples of `rst`. A shorter pulse changes no output.
- R12: While reset is accepted, `addr`, `seg`, `ie_flag`, `s6_err`, `ben_even`, `ben_odd` and `dt_r` are 0, and all five active-low strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset request |
| ale | input | 1 | Address latch strobe |
| abus | input | 16 | Address bits 15:0 (shared with data in the low DW bits) |
| ast | input | 4 | Address bits 19:16 / status bits |
| bhe_n | input | 1 | Byte-high enable, active low |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| mio | input | 1 | Memory/I-O select |
| addr | output | 20 | Latched address |
| seg | output | 4 | One-hot segment indication |
| ie_flag | output | 1 | Interrupt-enable status |
| s6_err | output | 1 | Sticky reserved-status error |
| ben_even | output | 1 | Even bank enable |
| ben_odd | output | 1 | Odd bank enable |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, high = outbound |

## Verification
The hardest case to reach is a reset pulse that is just too short. It arrives while `s6_err` is set and an address is latched. The bench raises `rst` for three edges in the middle of that state and confirms that nothing moves. A four-edge pulse then clears everything. The reserved-bit error is injected in one deliberate status phase, and the sticky flag is then watched across later bus cycles.

// File: rtl/mux_bus_demux.sv
module mux_bus_demux #(
  parameter int DW      = 16,
  parameter int RST_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ale,
  input  logic [15:0] abus,
  input  logic [3:0]  ast,
  input  logic        bhe_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        mio,
  output logic [19:0] addr,
  output logic [3:0]  seg,
  output logic        ie_flag,
  output logic        s6_err,
  output logic        ben_even,
  output logic        ben_odd,
  output logic        mem_rd_n,
  output logic        mem_wr_n,
  output logic        io_rd_n,
  output logic        io_wr_n,
  output logic        den_n,
  output logic        dt_r
);
  localparam logic MEM_LVL = (DW == 16);

  logic [RST_CYC-1:0] rst_sh;
  logic               in_rst, rst_take, is_mem, strobe, bhe_q;

  assign in_rst   = &rst_sh;
  assign rst_take = &{rst_sh[RST_CYC-2:0], rst};
  assign is_mem   = (mio == MEM_LVL);
  assign strobe   = ~rd_n | ~wr_n;

  always_ff @(posedge clk) begin
    rst_sh <= {rst_sh[RST_CYC-2:0], rst};
    if (rst_take) begin
      addr    <= '0;
      bhe_q   <= 1'b1;
      seg     <= '0;
      ie_flag <= 1'b0;
      s6_err  <= 1'b0;
    end else if (ale) begin
      addr  <= {ast, abus};
      bhe_q <= bhe_n;
      seg   <= '0;
    end else if (strobe) begin
      seg     <= 4'b0001 << ast[1:0];
      ie_flag <= ast[2];
      if (ast[3]) s6_err <= 1'b1;
    end
  end

  generate
    if (DW == 16) begin : g_two_bank
      assign ben_even = ~in_rst & ~addr[0];
      assign ben_odd  = ~in_rst & ~bhe_q;
    end else begin : g_one_lane
      assign ben_even = ~in_rst;
      assign ben_odd  = 1'b0;
    end
  endgenerate

  assign mem_rd_n = in_rst | rd_n | ~is_mem;
  assign mem_wr_n = in_rst | wr_n | ~is_mem;
  assign io_rd_n  = in_rst | rd_n | is_mem;
  assign io_wr_n  = in_rst | wr_n | is_mem;
  assign den_n    = in_rst | ~strobe;
  assign dt_r     = ~in_rst & ~wr_n;

  a_r1_latch: assert property (@(posedge clk) disable iff (rst)
    ale |=> addr == $past({ast, abus}));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(addr));
  a_r3_seg_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(seg));
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    s6_err |=> s6_err);
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}) || (!rd_n && !wr_n));
  a_r9_den: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n) |-> !den_n);
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst)
    in_rst |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && den_n && !dt_r));
endmodule

// File: tb/tb_mux_bus_demux.sv
module tb_mux_bus_demux;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, ale = 1'b0, bhe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mio = 1'b0;
  logic [15:0] abus = '0;
  logic [3:0]  ast = '0;

  logic [19:0] addr16, addr8;
  logic [3:0]  seg16, seg8;
  logic ie16, ie8, er16, er8, be16, be8, bo16, bo8;
  logic mr16, mw16, ir16, iw16, dn16, dt16, mr8, mw8, ir8, iw8, dn8, dt8;

  mux_bus_demux #(.DW(16)) dut (
    .clk(clk), .rst(rst), .ale(ale), .abus(abus), .ast(ast), .bhe_n(bhe_n),
    .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .addr(addr16), .seg(seg16),
    .ie_flag(ie16), .s6_err(er16), .ben_even(be16), .ben_odd(bo16),
    .mem_rd_n(mr16), .mem_wr_n(mw16), .io_rd_n(ir16), .io_wr_n(iw16),
    .den_n(dn16), .dt_r(dt16));

  mux_bus_demux #(.DW(8)) dut8 (
    .clk(clk), .rst(rst), .ale(ale), .abus(abus), .ast(ast), .bhe_n(bhe_n),
    .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .addr(addr8), .seg(seg8),
    .ie_flag(ie8), .s6_err(er8), .ben_even(be8), .ben_odd(bo8),
    .mem_rd_n(mr8), .mem_wr_n(mw8), .io_rd_n(ir8), .io_wr_n(iw8),
    .den_n(dn8), .dt_r(dt8));

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int          m_run = 0;
  logic [19:0] m_addr = '0;
  logic        m_bhe = 1'b1, m_ie = 1'b0, m_err = 1'b0;
  logic [3:0]  m_seg = '0;

  always @(posedge clk) begin
    if (rst) m_run = (m_run < 4) ? m_run + 1 : 4; else m_run = 0;
    if (m_run >= 4) begin
      m_addr = '0; m_bhe = 1'b1; m_seg = '0; m_ie = 1'b0; m_err = 1'b0;
    end else if (ale) begin
      m_addr = {ast, abus}; m_bhe = bhe_n; m_seg = '0;
    end else if (!rd_n || !wr_n) begin
      m_seg = '0; m_seg[ast[1:0]] = 1'b1; m_ie = ast[2];
      if (ast[3]) m_err = 1'b1;
    end
  end

  task automatic chk(input string req, input string name, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, name, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit rs, mem16, mem8;
    rs = (m_run >= 4);
    mem16 = mio; mem8 = !mio;
    chk("R1/R2/R12", "addr16", addr16, m_addr);
    chk("R1/R2/R12", "addr8", addr8, m_addr);
    chk("R3", "seg16", seg16, m_seg);
    chk("R3", "seg8", seg8, m_seg);
    chk("R4", "ie", {ie16, ie8}, {m_ie, m_ie});
    chk("R5", "s6_err", {er16, er8}, {m_err, m_err});
    chk("R6", "banks16", {be16, bo16}, rs ? 2'b00 : {~m_addr[0], ~m_bhe});
    chk("R7", "banks8", {be8, bo8}, rs ? 2'b00 : 2'b10);
    chk("R8", "strobes16", {mr16, mw16, ir16, iw16},
        {rs | rd_n | !mem16, rs | wr_n | !mem16, rs | rd_n | mem16, rs | wr_n | mem16});
    chk("R8", "strobes8", {mr8, mw8, ir8, iw8},
        {rs | rd_n | !mem8, rs | wr_n | !mem8, rs | rd_n | mem8, rs | wr_n | mem8});
    chk("R9", "den_n", {dn16, dn8}, {2{rs | (rd_n & wr_n)}});
    chk("R10", "dt_r", {dt16, dt8}, {2{~rs & ~wr_n}});
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic bus_cycle(input logic [19:0] a, input logic [1:0] sg, input logic ie,
                           input logic bh, input logic wr, input logic m, input logic s6);
    ale = 1; abus = a[15:0]; ast = a[19:16]; bhe_n = bh; rd_n = 1; wr_n = 1; mio = m;
    step();
    ale = 0; abus = ~a[15:0]; ast = {s6, ie, sg};
    if (wr) wr_n = 0; else rd_n = 0;
    step();
    abus = a[15:0] ^ 16'h5a5a;
    step();
    rd_n = 1; wr_n = 1; abus = 16'h0;
    step();
  endtask

  initial begin
    logic [19:0] lf;
    lf = 20'h3C5A1;
    repeat (4) @(negedge clk);
    compare();                          // R12 reset state
    step();
    rst = 0;
    step();
    for (int i = 0; i < 32; i++) begin  // R1-R10 varied patterns
      lf = {lf[18:0], lf[19] ^ lf[16]};
      bus_cycle({lf[19:1], i[3]}, i[1:0], i[4], i[2], i[0] ^ i[2], i[1] ^ i[3], 1'b0);
    end
    bus_cycle(20'hABCDE, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);  // R5 inject
    bus_cycle(20'h12340, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);  // R5 sticky
    ale = 0; rd_n = 0; mio = 1; ast = 4'h2;                    // R11 short pulse mid-read
    rst = 1; step(); step(); step();
    rst = 0; step(); step();
    rd_n = 1; step();
    rst = 1; repeat (4) step();                                // R11/R12 accepted
    rd_n = 0; wr_n = 0; step();
    rd_n = 1; wr_n = 1; rst = 0; step();
    for (int i = 0; i < 8; i++)
      bus_cycle(20'hF0F0F ^ (i * 20'h11111), i[1:0], i[0], i[1], i[2], i[0], 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule